// File: doc/BRIEF.md
# Page Entry Protection and Fault Classifier

This block sits at the end of a page table walk. It receives the last-level page table entry, the privilege of the access (kernel or user) and the kind of access (read, write, execute, or a permission probe). It decides whether the access may proceed. On success it returns the physical page number and the permission set to load into a TLB. On failure it returns a fault code and captures trap information for the exception logic.

Every request is qualified by a strobe, and the answer appears on registered outputs one cycle later. The tests run in a fixed order. Entry validity comes first. The mode-selected enable bits come second. The fault-on-operation masks come last. When several fault-on conditions could apply, execute is reported ahead of write, and write ahead of read. The trap registers keep their contents until the next faulting request.

Top module: `pte_prot_classifier`

## Requirements
- R1: While reset is asserted and afterwards until the first request, rsp_valid, rsp_ok, rsp_code, rsp_perm, rsp_ppn and all trap outputs read zero.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high. The other rsp_* outputs change only on such cycles and otherwise hold their values.
- R3: Entry bit 0 is the valid flag. When it is clear, the result is a fault with code 0 (translation not valid), whatever the other entry bits are.
- R4: Read permission comes from entry bit 8 in kernel mode (req_user=0) or bit 9 in user mode (req_user=1), and it grants both read and execute. Write permission comes from bit 12 (kernel) or bit 13 (user).
- R5: If the required access is not in the granted set, the result is a fault with code 1 (access violation).
- R6: Entry bit 1 removes read, bit 2 removes write and bit 3 removes execute from the granted set. If the required access is then missing, the fault code is 3 for execute, 4 for write and 2 for read.
- R7: An access violation is reported in preference to any fault-on-operation condition.
- R8: req_access encodes read=0, write=1, execute=2 and probe=3. A probe requires nothing, so it succeeds on any valid entry.
- R9: rsp_perm uses bit 0 for read, bit 1 for write and bit 2 for execute. On success it holds the masked granted set. On any fault it is zero. rsp_ppn always carries entry bits [PTE_W-1:PPN_LSB].
- R10: On a fault, trap_vaddr, trap_code and trap_access are loaded. trap_access is all ones for an execute access and the zero-extended access type otherwise. These registers hold their values through successful requests and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_pte | input | PTE_W | Final-level page table entry |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_user | input | 1 | 0 = kernel, 1 = user |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 probe |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_ok | output | 1 | Access permitted |
| rsp_code | output | 3 | Fault code when rsp_ok is low, else 0 |
| rsp_perm | output | 3 | Permission set for the TLB (exec, write, read) |
| rsp_ppn | output | PTE_W-PPN_LSB | Physical page number field |
| trap_vaddr | output | VA_W | Faulting virtual address |
| trap_code | output | 3 | Latched fault code |
| trap_access | output | ACC_ARG_W | Encoded access type of the fault |

## Verification
The bench builds the block with a 64-bit entry, a 32-bit page-number offset, a 43-bit virtual address and a 64-bit trap access argument. At that width the all-ones execute marker covers a full machine word, so a zero-extension or truncation fault becomes visible. The wide page-number field also exposes any slip in where that field is sliced from the entry. Directed vectors cover each mode-enable and fault-on bit in isolation. Long random runs then mix valid, invalid and probe requests in both modes.

// File: rtl/pte_cls_pkg.sv
package pte_cls_pkg;

   typedef enum logic [2:0] {
      FC_TNV = 3'd0,
      FC_ACV = 3'd1,
      FC_FOR = 3'd2,
      FC_FOE = 3'd3,
      FC_FOW = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      AT_READ  = 2'd0,
      AT_WRITE = 2'd1,
      AT_EXEC  = 2'd2,
      AT_PROBE = 2'd3
   } acc_e;

   localparam int PERM_W  = 3;
   localparam int P_READ  = 0;
   localparam int P_WRITE = 1;
   localparam int P_EXEC  = 2;

   localparam int B_VALID = 0;
   localparam int B_FO_LO = 1;
   localparam int B_FO_HI = 3;
   localparam int B_RD_K  = 8;
   localparam int B_WR_K  = 12;
   localparam int N_MODES = 2;

endpackage

// File: rtl/pte_grant.sv
module pte_grant
   import pte_cls_pkg::*;
#(
   parameter int MODES = N_MODES
) (
   input  logic [MODES-1:0]  rd_en,
   input  logic [MODES-1:0]  wr_en,
   input  logic              mode,
   output logic [PERM_W-1:0] grant
);
   logic rd_sel;
   logic wr_sel;

   generate
      if (MODES == 2) begin : g_two_mode
         assign rd_sel = rd_en[mode];
         assign wr_sel = wr_en[mode];
      end else begin : g_bad_modes
         initial $error("pte_grant supports exactly two modes");
         assign rd_sel = 1'b0;
         assign wr_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      grant          = '0;
      grant[P_READ]  = rd_sel;
      grant[P_EXEC]  = rd_sel;
      grant[P_WRITE] = wr_sel;
   end
endmodule

// File: rtl/pte_fo_mask.sv
module pte_fo_mask
   import pte_cls_pkg::*;
(
   input  logic [PERM_W-1:0] grant,
   input  logic [PERM_W-1:0] fo_bits,
   output logic [PERM_W-1:0] masked
);
   generate
      for (genvar i = 0; i < PERM_W; i++) begin : g_bit
         assign masked[i] = grant[i] & ~fo_bits[i];
      end
   endgenerate
endmodule

// File: rtl/pte_judge.sv
module pte_judge
   import pte_cls_pkg::*;
(
   input  logic              entry_ok,
   input  logic [PERM_W-1:0] need,
   input  logic [PERM_W-1:0] grant,
   input  logic [PERM_W-1:0] masked,
   output logic              pass,
   output fault_e            code
);
   logic any_need;
   logic hit_grant;
   logic hit_mask;

   assign any_need  = |need;
   assign hit_grant = |(grant & need);
   assign hit_mask  = |(masked & need);

   always_comb begin
      pass = 1'b0;
      code = FC_TNV;
      if (!entry_ok) begin
         code = FC_TNV;
      end else if (any_need && !hit_grant) begin
         code = FC_ACV;
      end else if (any_need && !hit_mask) begin
         if (need[P_EXEC])       code = FC_FOE;
         else if (need[P_WRITE]) code = FC_FOW;
         else                    code = FC_FOR;
      end else begin
         pass = 1'b1;
      end
   end

   always_comb begin
      if (pass) a_r3_pass_needs_valid : assert (entry_ok);
   end
endmodule

// File: rtl/pte_prot_classifier.sv
module pte_prot_classifier
   import pte_cls_pkg::*;
#(
   parameter int PTE_W     = 64,
   parameter int PPN_LSB   = 32,
   parameter int VA_W      = 43,
   parameter int ACC_ARG_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [PTE_W-1:0]         req_pte,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic                     req_user,
   input  logic [1:0]               req_access,
   output logic                     rsp_valid,
   output logic                     rsp_ok,
   output logic [2:0]               rsp_code,
   output logic [PERM_W-1:0]        rsp_perm,
   output logic [PTE_W-PPN_LSB-1:0] rsp_ppn,
   output logic [VA_W-1:0]          trap_vaddr,
   output logic [2:0]               trap_code,
   output logic [ACC_ARG_W-1:0]     trap_access
);
   localparam int PPN_W = PTE_W - PPN_LSB;

   generate
      if (PPN_LSB < B_WR_K + N_MODES + 1) begin : g_chk_lsb
         initial $error("PPN_LSB overlaps the permission field");
      end
      if (PPN_LSB >= PTE_W) begin : g_chk_w
         initial $error("PTE_W must exceed PPN_LSB");
      end
      if (ACC_ARG_W < 2) begin : g_chk_acc
         initial $error("ACC_ARG_W must be at least 2");
      end
      if (VA_W < 1) begin : g_chk_va
         initial $error("VA_W must be positive");
      end
   endgenerate

   logic [PERM_W-1:0] need;
   logic [PERM_W-1:0] grant;
   logic [PERM_W-1:0] masked;
   logic              pass;
   fault_e            code;
   logic [ACC_ARG_W-1:0] acc_arg;
   logic              unused_pte;

   assign unused_pte = ^{req_pte[B_WR_K-1:B_RD_K+N_MODES],
                         req_pte[B_RD_K-1:B_FO_HI+1],
                         req_pte[PPN_LSB-1:B_WR_K+N_MODES]};

   always_comb begin
      need = '0;
      unique case (acc_e'(req_access))
         AT_READ:  need[P_READ]  = 1'b1;
         AT_WRITE: need[P_WRITE] = 1'b1;
         AT_EXEC:  need[P_EXEC]  = 1'b1;
         default:  need = '0;
      endcase
   end

   pte_grant #(.MODES(N_MODES)) u_grant (
      .rd_en (req_pte[B_RD_K +: N_MODES]),
      .wr_en (req_pte[B_WR_K +: N_MODES]),
      .mode  (req_user),
      .grant (grant)
   );

   pte_fo_mask u_mask (
      .grant   (grant),
      .fo_bits (req_pte[B_FO_HI:B_FO_LO]),
      .masked  (masked)
   );

   pte_judge u_judge (
      .entry_ok (req_pte[B_VALID]),
      .need     (need),
      .grant    (grant),
      .masked   (masked),
      .pass     (pass),
      .code     (code)
   );

   generate
      if (ACC_ARG_W > 2) begin : g_acc_wide
         assign acc_arg = (req_access == AT_EXEC) ? '1
                        : {{(ACC_ARG_W-2){1'b0}}, req_access};
      end else begin : g_acc_narrow
         assign acc_arg = (req_access == AT_EXEC) ? '1 : req_access;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_ok      <= 1'b0;
         rsp_code    <= '0;
         rsp_perm    <= '0;
         rsp_ppn     <= '0;
         trap_vaddr  <= '0;
         trap_code   <= '0;
         trap_access <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_ok   <= pass;
            rsp_code <= pass ? 3'd0 : code;
            rsp_perm <= pass ? masked : '0;
            rsp_ppn  <= req_pte[PTE_W-1:PPN_LSB];
            if (!pass) begin
               trap_vaddr  <= req_vaddr;
               trap_code   <= code;
               trap_access <= acc_arg;
            end
         end
      end
   end

   a_r2_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_rsp_drops : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r3_invalid_tnv : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_pte[B_VALID] |=> rsp_valid && !rsp_ok && rsp_code == 3'd0);
   a_r4_user_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_pte[B_VALID] && req_user && !req_pte[B_RD_K+1]
      && req_access == 2'd0 |=> !rsp_ok && rsp_code == 3'd1);
   a_r8_probe_ok : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_pte[B_VALID] && req_access == 2'd3 |=> rsp_ok);
   a_r9_fault_no_perm : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ok |-> rsp_perm == '0);
   a_r10_trap_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && !rsp_ok) |-> $stable(trap_code) && $stable(trap_vaddr)
                                   && $stable(trap_access));
   a_r10_trap_code_match : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ok |-> trap_code == rsp_code);
endmodule

// File: tb/tb_pte_prot_classifier.sv
`timescale 1ns/1ps
module tb_pte_prot_classifier;
   localparam int PTE_W = 64;
   localparam int PPN_LSB = 32;
   localparam int VA_W = 43;
   localparam int ACC_ARG_W = 64;
   localparam int PPN_W = PTE_W - PPN_LSB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [PTE_W-1:0] req_pte = '0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic req_user = 1'b0;
   logic [1:0] req_access = '0;
   logic rsp_valid, rsp_ok;
   logic [2:0] rsp_code, rsp_perm, trap_code;
   logic [PPN_W-1:0] rsp_ppn;
   logic [VA_W-1:0] trap_vaddr;
   logic [ACC_ARG_W-1:0] trap_access;

   int vectors = 0;
   int miscompares = 0;

   logic e_valid = 0, e_ok = 0;
   logic [2:0] e_code = 0, e_perm = 0, e_tcode = 0;
   logic [PPN_W-1:0] e_ppn = 0;
   logic [VA_W-1:0] e_tva = 0;
   logic [ACC_ARG_W-1:0] e_tacc = 0;

   always #2 clk = ~clk;

   pte_prot_classifier #(.PTE_W(PTE_W), .PPN_LSB(PPN_LSB), .VA_W(VA_W),
                         .ACC_ARG_W(ACC_ARG_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
      .req_vaddr(req_vaddr), .req_user(req_user), .req_access(req_access),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_code(rsp_code),
      .rsp_perm(rsp_perm), .rsp_ppn(rsp_ppn), .trap_vaddr(trap_vaddr),
      .trap_code(trap_code), .trap_access(trap_access));

   // Behavioural reference: returns ok, code, perm
   task automatic model(input logic [63:0] p, input bit usr, input int acc,
                        output bit ok, output int code, output int perm);
      int g, need, m;
      ok = 0; code = 0; perm = 0;
      if (!p[0]) return;
      g = 0;
      if (usr ? p[9] : p[8]) g = g | 5;
      if (usr ? p[13] : p[12]) g = g | 2;
      need = (acc == 3) ? 0 : (1 << acc);
      if (need != 0 && (g & need) == 0) begin code = 1; return; end
      m = g;
      if (p[1]) m = m & 6;
      if (p[2]) m = m & 5;
      if (p[3]) m = m & 3;
      if (need != 0 && (m & need) == 0) begin
         code = (need == 4) ? 3 : (need == 2) ? 4 : 2;
         return;
      end
      ok = 1; perm = m;
   endtask

   task automatic compare(input string tag);
      bit bad;
      vectors++;
      bad = (rsp_valid !== e_valid) || (rsp_ok !== e_ok) || (rsp_code !== e_code)
         || (rsp_perm !== e_perm) || (rsp_ppn !== e_ppn) || (trap_vaddr !== e_tva)
         || (trap_code !== e_tcode) || (trap_access !== e_tacc);
      if (bad) begin
         miscompares++;
         $display("FAIL %s: got v=%0b ok=%0b code=%0d perm=%0d ppn=%h tva=%h tc=%0d ta=%h exp v=%0b ok=%0b code=%0d perm=%0d ppn=%h tva=%h tc=%0d ta=%h",
            tag, rsp_valid, rsp_ok, rsp_code, rsp_perm, rsp_ppn, trap_vaddr, trap_code,
            trap_access, e_valid, e_ok, e_code, e_perm, e_ppn, e_tva, e_tcode, e_tacc);
      end
   endtask

   task automatic step(input bit v, input logic [63:0] p, input logic [VA_W-1:0] va,
                       input bit usr, input logic [1:0] acc, input string tag);
      bit ok; int code, perm;
      @(negedge clk);
      req_valid = v; req_pte = p; req_vaddr = va; req_user = usr; req_access = acc;
      e_valid = v;
      if (v) begin
         model(p, usr, int'(acc), ok, code, perm);
         e_ok = ok; e_code = 3'(code); e_perm = 3'(perm); e_ppn = p[63:32];
         if (!ok) begin
            e_tva = va; e_tcode = 3'(code);
            e_tacc = (acc == 2) ? '1 : ACC_ARG_W'(acc);
         end
      end
      @(posedge clk); #1;
      compare(tag);
   endtask

   initial begin
      #400000;
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 compare("R1");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 compare("R1");
      // R4 kernel read via bit 8, user read via bit 9
      step(1, 64'h0000_1234_0000_0101, 43'h100, 0, 2'd0, "R4");
      step(1, 64'h0000_1234_0000_0101, 43'h104, 1, 2'd0, "R5");
      step(1, 64'h0000_0055_0000_0201, 43'h108, 1, 2'd0, "R4");
      step(1, 64'h0000_0055_0000_0201, 43'h10c, 1, 2'd2, "R4");
      step(1, 64'h0000_0066_0000_1001, 43'h110, 0, 2'd1, "R4");
      step(1, 64'h0000_0066_0000_2001, 43'h114, 0, 2'd1, "R5");
      step(1, 64'h0000_0066_0000_2101, 43'h118, 1, 2'd1, "R4");
      // R3 invalid entry with every other bit set
      step(1, 64'hFFFF_FFFF_FFFF_FFFE, 43'h7ff_0000_0000, 0, 2'd2, "R3");
      // R2 idle cycles: outputs and traps hold
      step(0, 64'h0, 43'h0, 0, 2'd0, "R2");
      step(0, 64'hFFFF, 43'h1, 1, 2'd3, "R2");
      // R6 fault-on bits
      step(1, 64'h0000_0001_0000_3303, 43'h200, 0, 2'd0, "R6");
      step(1, 64'h0000_0001_0000_3305, 43'h204, 1, 2'd1, "R6");
      step(1, 64'h0000_0001_0000_3309, 43'h208, 0, 2'd2, "R6");
      step(1, 64'h0000_0001_0000_3309, 43'h20c, 0, 2'd0, "R6");
      // R7 access violation beats fault-on
      step(1, 64'h0000_0001_0000_000F, 43'h300, 0, 2'd1, "R7");
      // R8 probe
      step(1, 64'h0000_0002_0000_000F, 43'h400, 1, 2'd3, "R8");
      step(1, 64'h0000_0002_0000_0000, 43'h404, 0, 2'd3, "R8");
      // R10 trap held across successes, exec arg all ones
      step(1, 64'h0000_0003_0000_0101, 43'h500, 0, 2'd2, "R10");
      step(1, 64'h0000_0003_0000_0109, 43'h504, 0, 2'd2, "R10");
      step(1, 64'h0000_0003_0000_3301, 43'h508, 1, 2'd0, "R10");
      step(0, 64'h0, 43'h0, 0, 2'd0, "R10");
      // R9 random mixture
      for (int i = 0; i < 2000; i++) begin
         logic [63:0] p;
         p = {$urandom, $urandom};
         if ($urandom_range(0, 3) != 0) p[0] = 1'b1;
         step($urandom_range(0, 4) != 0, p, VA_W'({$urandom, $urandom}),
              1'($urandom), 2'($urandom), "R9");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule